// File: doc/BRIEF.md
# Opcode Fetch and Program Counter Step Sequencer

This block is the front end of a small 8-bit processor. Each instruction starts with an opcode fetch cycle that reads the byte at the program counter. It is followed by a second cycle that always reads the next byte, because the opcode has not been decoded when that read is set up. During the second cycle the block decides whether the program counter moves a second time. Opcodes that a bit-pattern predecode marks as single-byte keep the counter where it is, so the byte that was read is fetched again as the next opcode. All other opcodes, including the break opcode 0x00 and the two return opcodes, step past it.

A pending hardware interrupt is sampled only in the opcode fetch cycle. When it is seen, the block loads 0x00 into the instruction register in place of the bus byte, so that the break microsequence follows. It holds the program counter through both cycles, so the address of the interrupted instruction is kept for the return. Execution, stack pushes and vector fetch belong to the blocks downstream. Those blocks read the instruction register, the one-byte flag and the interrupt-taken flag.

Top module: `opf_frontend`

## Requirements
- R1: While `rst` is high, the next clock edge loads `o_pc` from `i_rst_vec`, puts the block in the opcode fetch cycle (`o_sync`=1) and clears `o_irq_taken`, `o_ir` and `o_one_byte`.
- R2: In an opcode fetch cycle with `i_irq_pend` low, the edge latches `i_rdata` into `o_ir`, clears `o_irq_taken` and advances `o_pc` by one.
- R3: Cycles alternate strictly between opcode fetch (`o_sync`=1) and the following-byte read (`o_sync`=0). In both cycles `o_addr` equals `o_pc`.
- R4: An opcode with `(op & 0x0D) == 0x08` (bit 3 set, bits 2 and 0 clear) sets `o_one_byte`. On its second cycle `o_pc` does not advance, so the next fetch address is the opcode address plus one.
- R5: Every other opcode, including 0x00, 0x40 and 0x60, clears `o_one_byte` and advances `o_pc` on the second cycle. The next fetch address is the opcode address plus two.
- R6: In an opcode fetch cycle with `i_irq_pend` high, the edge loads 0x00 into `o_ir`, sets `o_irq_taken` and clears `o_one_byte`. `o_pc` stays unchanged through both cycles, so the next fetch address equals the interrupted address.
- R7: `i_irq_pend` is ignored in the second cycle: it changes neither `o_ir`, `o_irq_taken` nor the program counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_rst_vec | input | ADDR_W | Program counter value loaded at reset |
| i_rdata | input | 8 | Read data bus |
| i_irq_pend | input | 1 | Hardware interrupt pending |
| o_addr | output | ADDR_W | Read address |
| o_pc | output | ADDR_W | Program counter |
| o_ir | output | 8 | Latched instruction register |
| o_one_byte | output | 1 | Latched opcode is single-byte |
| o_irq_taken | output | 1 | Current 0x00 was forced by an interrupt |
| o_sync | output | 1 | Opcode fetch cycle marker |

## Verification
Every one of the 256 opcode values is fetched in turn. Comparing next fetch addresses of plus one and plus two separates the single-byte pattern from its neighbours, such as 0x09 and 0x0C, and from the break and return opcodes. Interrupts are raised in front of both a single-byte opcode and a multi-byte opcode, to show that the forced 0x00 neither inherits the one-byte flag nor steps the counter. A request that is raised only in the second cycle must leave the instruction stream untouched.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam int OP_W = 8;

    // single-byte opcode predecode: bit3=1, bit2=0, bit0=0
    localparam logic [OP_W-1:0] ONE_BYTE_MASK  = 8'h0D;
    localparam logic [OP_W-1:0] ONE_BYTE_MATCH = 8'h08;
    localparam logic [OP_W-1:0] BREAK_OP       = 8'h00;

    typedef enum logic {
        ST_FETCH   = 1'b0,
        ST_OPERAND = 1'b1
    } opf_state_e;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic            one_byte;
        logic            irq;
    } ir_slot_t;

    function automatic logic is_one_byte(input logic [OP_W-1:0] op);
        return (op & ONE_BYTE_MASK) == ONE_BYTE_MATCH;
    endfunction

endpackage

// File: rtl/opf_predecode.sv
module opf_predecode
    import opf_pkg::*;
(
    input  logic [OP_W-1:0] i_byte,
    input  logic            i_force_brk,
    output ir_slot_t        o_slot
);
    always_comb begin
        if (i_force_brk) begin
            o_slot.op       = BREAK_OP;
            o_slot.one_byte = 1'b0;
            o_slot.irq      = 1'b1;
        end else begin
            o_slot.op       = i_byte;
            o_slot.one_byte = is_one_byte(i_byte);
            o_slot.irq      = 1'b0;
        end
    end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     i_irq_pend,
    input  ir_slot_t i_next_slot,
    output logic     o_take_irq,
    output logic     o_pc_step,
    output logic     o_fetch,
    output ir_slot_t o_slot
);
    opf_state_e state_q;
    ir_slot_t   slot_q;

    assign o_fetch    = (state_q == ST_FETCH);
    assign o_take_irq = o_fetch && i_irq_pend;
    assign o_slot     = slot_q;

    always_comb begin
        if (o_fetch)
            o_pc_step = !i_irq_pend;
        else
            o_pc_step = !(slot_q.one_byte || slot_q.irq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            slot_q  <= '0;
        end else if (o_fetch) begin
            state_q <= ST_OPERAND;
            slot_q  <= i_next_slot;
        end else begin
            state_q <= ST_FETCH;
        end
    end
endmodule

// File: rtl/opf_pc_unit.sv
module opf_pc_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] i_rst_vec,
    input  logic              i_step,
    output logic [ADDR_W-1:0] o_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    assign o_pc = pc_q;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= i_rst_vec;
        else if (i_step)
            pc_q <= pc_q + STEP;
    end
endmodule

// File: rtl/opf_frontend.sv
module opf_frontend
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] i_rst_vec,
    input  logic [OP_W-1:0]   i_rdata,
    input  logic              i_irq_pend,
    output logic [ADDR_W-1:0] o_addr,
    output logic [ADDR_W-1:0] o_pc,
    output logic [OP_W-1:0]   o_ir,
    output logic              o_one_byte,
    output logic              o_irq_taken,
    output logic              o_sync
);
    ir_slot_t          next_slot;
    ir_slot_t          cur_slot;
    logic              take_irq;
    logic              pc_step;
    logic              fetch;
    logic [ADDR_W-1:0] pc;

    opf_predecode u_pd (
        .i_byte      (i_rdata),
        .i_force_brk (take_irq),
        .o_slot      (next_slot)
    );

    opf_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .i_irq_pend  (i_irq_pend),
        .i_next_slot (next_slot),
        .o_take_irq  (take_irq),
        .o_pc_step   (pc_step),
        .o_fetch     (fetch),
        .o_slot      (cur_slot)
    );

    opf_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .i_rst_vec (i_rst_vec),
        .i_step    (pc_step),
        .o_pc      (pc)
    );

    // both cycles of an instruction read at the current PC
    assign o_addr      = pc;
    assign o_pc        = pc;
    assign o_ir        = cur_slot.op;
    assign o_one_byte  = cur_slot.one_byte;
    assign o_irq_taken = cur_slot.irq;
    assign o_sync      = fetch;
endmodule

// File: rtl/opf_frontend_chk.sv
module opf_frontend_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] i_rst_vec,
    input logic [7:0]        i_rdata,
    input logic              i_irq_pend,
    input logic [ADDR_W-1:0] o_addr,
    input logic [ADDR_W-1:0] o_pc,
    input logic [7:0]        o_ir,
    input logic              o_one_byte,
    input logic              o_irq_taken,
    input logic              o_sync
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(1);

    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (o_pc == $past(i_rst_vec)) && o_sync && !o_irq_taken && !o_one_byte);

    // R2
    opcode_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (o_sync && !i_irq_pend) |=> (o_ir == $past(i_rdata)) && !o_irq_taken
                                    && (o_pc == $past(o_pc) + INC));

    // R3
    fetch_to_operand_chk: assert property (@(posedge clk) disable iff (rst)
        o_sync |=> !o_sync);

    // R3
    operand_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        !o_sync |=> o_sync);

    // R4
    one_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!o_sync && o_one_byte) |=> o_pc == $past(o_pc));

    // R5
    two_byte_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!o_sync && !o_one_byte && !o_irq_taken) |=> o_pc == $past(o_pc) + INC);

    // R6
    irq_force_chk: assert property (@(posedge clk) disable iff (rst)
        (o_sync && i_irq_pend) |=> (o_ir == 8'h00) && o_irq_taken && !o_one_byte
                                   && (o_pc == $past(o_pc)));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!o_sync && o_irq_taken) |=> o_pc == $past(o_pc));

    // R7
    operand_ignores_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !o_sync |=> $stable(o_ir) && $stable(o_irq_taken));
endmodule

bind opf_frontend opf_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .i_rst_vec   (i_rst_vec),
    .i_rdata     (i_rdata),
    .i_irq_pend  (i_irq_pend),
    .o_addr      (o_addr),
    .o_pc        (o_pc),
    .o_ir        (o_ir),
    .o_one_byte  (o_one_byte),
    .o_irq_taken (o_irq_taken),
    .o_sync      (o_sync)
);

// File: tb/tb_opf_frontend.sv
module tb_opf_frontend;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] rst_vec = 16'hC000;
    logic [7:0]        rdata = 8'h00;
    logic              irq = 1'b0;
    logic [ADDR_W-1:0] addr, pc;
    logic [7:0]        ir;
    logic              one_byte, irq_taken, sync;

    always #2 clk = ~clk;   // 250 MHz

    opf_frontend #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .i_rst_vec(rst_vec), .i_rdata(rdata),
        .i_irq_pend(irq), .o_addr(addr), .o_pc(pc), .o_ir(ir),
        .o_one_byte(one_byte), .o_irq_taken(irq_taken), .o_sync(sync)
    );

    typedef struct {
        logic [7:0]        ir;
        logic              ob;
        logic              tk;
        logic [ADDR_W-1:0] next_pc;
        string             req;
    } exp_t;

    exp_t              sb[$];
    int                checks = 0;
    int                fails  = 0;
    bit                done   = 0;
    logic [ADDR_W-1:0] model_pc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver: called at a negedge inside an opcode fetch cycle
    task automatic run_instr(input logic [7:0] op, input bit irq_f, input bit irq_s,
                             input string req);
        exp_t e;
        logic [ADDR_W-1:0] mid;
        chk(sync == 1'b1, "R3", "sync in fetch", sync, 1);
        chk(addr == model_pc, "R3", "fetch addr", addr, model_pc);
        rdata = op;
        irq   = irq_f;
        @(posedge clk);
        @(negedge clk);
        mid = irq_f ? model_pc : model_pc + 16'd1;
        chk(sync == 1'b0, "R3", "sync in operand cycle", sync, 0);
        chk(addr == mid, irq_f ? "R6" : "R2", "operand addr", addr, mid);
        e.ir = irq_f ? 8'h00 : op;
        e.ob = !irq_f && ((op & 8'h0D) == 8'h08);
        e.tk = irq_f;
        e.next_pc = (irq_f || e.ob) ? mid : mid + 16'd1;
        e.req = req;
        sb.push_back(e);
        model_pc = e.next_pc;
        rdata = 8'hA5;
        irq   = irq_s;
        @(posedge clk);
        @(negedge clk);
        irq = 1'b0;
    endtask

    // monitor: compares at the start of the next opcode fetch
    always @(negedge clk) begin
        if (!rst && sync && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(ir == e.ir, e.req, "ir", ir, e.ir);
            chk(one_byte == e.ob, e.req, "one_byte", one_byte, e.ob);
            chk(irq_taken == e.tk, e.req, "irq_taken", irq_taken, e.tk);
            chk(pc == e.next_pc, e.req, "next fetch pc", pc, e.next_pc);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc == 16'hC000, "R1", "reset pc", pc, 16'hC000);
        chk(sync == 1'b1, "R1", "reset sync", sync, 1);
        chk(irq_taken == 1'b0, "R1", "reset irq_taken", irq_taken, 0);
        chk(ir == 8'h00, "R1", "reset ir", ir, 0);
        model_pc = 16'hC000;
        rst = 1'b0;

        run_instr(8'hA9, 0, 0, "R2");
        run_instr(8'hE8, 0, 0, "R4");   // single-byte
        run_instr(8'h0A, 0, 0, "R4");
        run_instr(8'h00, 0, 0, "R5");   // break steps twice
        run_instr(8'h60, 0, 0, "R5");
        run_instr(8'h40, 0, 0, "R5");
        run_instr(8'h09, 0, 0, "R5");
        run_instr(8'h0C, 0, 0, "R5");
        run_instr(8'hE8, 1, 0, "R6");   // irq over single-byte opcode
        run_instr(8'hA9, 1, 0, "R6");   // irq over two-byte opcode
        run_instr(8'hA9, 0, 0, "R2");   // irq_taken cleared again
        run_instr(8'h8D, 0, 1, "R7");   // irq only in second cycle
        run_instr(8'hEA, 0, 1, "R7");
        for (int k = 0; k < 256; k++)
            run_instr(8'(k), 0, 0, ((k & 8'h0D) == 8'h08) ? "R4" : "R5");

        // second reset with another vector
        rst = 1'b1;
        rst_vec = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        chk(pc == 16'h1234, "R1", "reset reload pc", pc, 16'h1234);
        chk(sync == 1'b1 && irq_taken == 1'b0, "R1", "reset reload flags",
            {sync, irq_taken}, 2'b10);
        sb.delete();
        model_pc = 16'h1234;
        rst = 1'b0;
        run_instr(8'h00, 1, 0, "R6");
        run_instr(8'h00, 0, 0, "R5");
        @(negedge clk);
        chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule